// File: doc/BRIEF.md
# DAC Reset and Power-Down Controller

This block sits in the digital core of a 16-bit voltage-output converter. It brings three reset causes together: a power-on reset, an active-low reset pin and a reset command sent over the serial port. On any of them it loads the input register and the output latch with a start-up code, which is zero scale or midscale depending on a strap pin. It also works out whether the analog path must be powered down. A pin and two configuration bits can each request power-down. The block drives a single power-down enable towards the analog side.

The serial shifter is outside this block. It hands over, in the system clock domain, a frame-select level (`cs_n`), a one-cycle strobe for each received bit and the bit value. The block counts and collects the bits. At the end of a frame it decodes the command and converts the data code to straight binary when two's-complement input is selected. A frame in which the reset pin fired is discarded in full, and the `frame_drop` flag marks it for the frame decoder.

Top module: `dac_rstpd_ctrl`

## Requirements
- R1: While `por_n` or `rst_pin_n` is low, `rst_active` is high. Within one clock edge, `input_reg` and `dac_latch` both hold the start-up code: 16'h0000 when `mid_strap` is low and 16'h8000 when it is high.
- R2: Reset assertion is asynchronous. Release is synchronous: after both reset inputs are high, `rst_active` stays high through the first clock edge and falls at the second.
- R3: A frame is 24 bits, MSB first. Bits 23:20 are ignored, bits 19:16 are the command and bits 15:0 are the data. A frame is acted on only when `cs_n` rises after exactly 24 strobes. Frames of any other length change nothing.
- R4: Command 1 writes `input_reg`, command 2 copies `input_reg` into `dac_latch`, and command 3 writes both. The result is visible after the clock edge that first samples `cs_n` high.
- R5: With `fmt_twos` low, data is stored unchanged. With `fmt_twos` high, data bit 15 is inverted before it is stored.
- R6: If a reset pin pulse lands inside a frame, `frame_drop` goes high and stays high until `cs_n` is seen high. No part of that frame is committed, even if 24 strobes follow the reset.
- R7: A valid command-4 frame with data bit 15 set raises `rst_active` for one cycle after the frame ends. On the next edge it loads the start-up code and clears both power-down bits. The same bits in an invalid frame do nothing.
- R8: `pd_en` is high when `pd_pin` is high, or when power-down bit A (data bit 14 of command 4) is set, or when power-down bit B (data bit 14 of command 12) is set.
- R9: `pd_en` returns low only when `pd_pin` is low and both power-down bits are clear.
- R10: In power-down, write frames still take effect. Entering or leaving power-down leaves `input_reg` and `dac_latch` unchanged.
- R11: Frames carrying any other command change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| rst_pin_n | input | 1 | Hardware reset pin, active low |
| mid_strap | input | 1 | Start-up code select: 0 = zero scale, 1 = midscale |
| fmt_twos | input | 1 | Data format: 0 = straight binary, 1 = two's complement |
| pd_pin | input | 1 | Hardware power-down request |
| cs_n | input | 1 | Frame select from shifter, active low |
| bit_strobe | input | 1 | One-cycle pulse per received bit |
| bit_in | input | 1 | Received bit value |
| rst_active | output | 1 | Core is in reset |
| frame_drop | output | 1 | Current frame is discarded |
| pd_en | output | 1 | Power-down enable to the analog path |
| input_reg | output | 16 | Input register, straight binary |
| dac_latch | output | 16 | Output latch, straight binary |

## Verification
Suppose the frame-end or reset-tracking state is wrong. Then a discarded frame shows up as a changed `input_reg` or `dac_latch` one edge after `cs_n` rises, or a good frame fails to land in that same cycle. A wrong software-reset pulse moves both registers to the start-up code and drops `pd_en` exactly two edges after the frame ends, so a pulse that comes early, late or not at all is visible at the ports. A power-down bit stuck in the wrong state keeps `pd_en` high after the pin and both bits have been cleared, and the bench reads this right after each configuration frame.

// File: rtl/dac_rpd_pkg.sv
package dac_rpd_pkg;

  localparam int unsigned CMD_W   = 4;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned KEEP_W  = CMD_W + DATA_W;

  localparam logic [CMD_W-1:0] CMD_WR_IN   = 4'h1;
  localparam logic [CMD_W-1:0] CMD_LOAD    = 4'h2;
  localparam logic [CMD_W-1:0] CMD_WR_BOTH = 4'h3;
  localparam logic [CMD_W-1:0] CMD_CFG_A   = 4'h4;
  localparam logic [CMD_W-1:0] CMD_CFG_B   = 4'hC;

  localparam int unsigned SRST_BIT = 15;
  localparam int unsigned PD_BIT   = 14;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } frame_t;

endpackage

// File: rtl/rpd_reset_sync.sv
module rpd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_raw_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_raw_n) begin
    if (!rst_raw_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rpd_frame_track.sv
module rpd_frame_track
  import dac_rpd_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 24
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n,
  input  logic   bit_strobe,
  input  logic   bit_in,
  output logic   frame_ok,
  output frame_t frame,
  output logic   poisoned
);

  localparam int unsigned CNT_MAX = FRAME_BITS + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [KEEP_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cs_q;
  logic              poison_q, poison_d;
  logic              frame_end;
  logic              shift_en;

  assign shift_en  = !cs_n && bit_strobe;
  assign frame_end = !cs_q && cs_n;

  always_comb begin
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    poison_d = poison_q;
    if (cs_n) begin
      cnt_d    = '0;
      poison_d = 1'b0;
    end else if (shift_en) begin
      shift_d = {shift_q[KEEP_W-2:0], bit_in};
      if (cnt_q != CNT_W'(CNT_MAX)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      cs_q     <= 1'b1;
      poison_q <= 1'b1;
    end else begin
      if (shift_en) begin
        shift_q <= shift_d;
      end
      cnt_q    <= cnt_d;
      cs_q     <= cs_n;
      poison_q <= poison_d;
    end
  end

  assign frame_ok = frame_end && !poison_q && (cnt_q == CNT_W'(FRAME_BITS));
  assign frame    = frame_t'(shift_q);
  assign poisoned = poison_q;

endmodule

// File: rtl/rpd_regs.sv
module rpd_regs
  import dac_rpd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MID_CODE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  frame_t            frame,
  input  logic              fmt_twos,
  input  logic              mid_strap,
  output logic [DATA_W-1:0] input_reg,
  output logic [DATA_W-1:0] dac_latch,
  output logic              pd_a,
  output logic              pd_b,
  output logic              srst_q
);

  logic [DATA_W-1:0] in_q, in_d, lat_q, lat_d;
  logic [DATA_W-1:0] start_code;
  logic [DATA_W-1:0] code_sb;
  logic              load_start;
  logic              pd_a_q, pd_a_d, pd_b_q, pd_b_d;
  logic              srst_d;

  assign start_code = mid_strap ? MID_CODE : '0;
  assign load_start = !rst_n || srst_q;
  assign code_sb    = {frame.data[DATA_W-1] ^ fmt_twos, frame.data[DATA_W-2:0]};

  always_comb begin
    in_d  = in_q;
    lat_d = lat_q;
    if (load_start) begin
      in_d  = start_code;
      lat_d = start_code;
    end else if (frame_ok) begin
      case (frame.cmd)
        CMD_WR_IN:   in_d = code_sb;
        CMD_LOAD:    lat_d = in_q;
        CMD_WR_BOTH: begin
          in_d  = code_sb;
          lat_d = code_sb;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    in_q  <= in_d;
    lat_q <= lat_d;
  end

  always_comb begin
    pd_a_d = pd_a_q;
    pd_b_d = pd_b_q;
    srst_d = 1'b0;
    if (srst_q) begin
      pd_a_d = 1'b0;
      pd_b_d = 1'b0;
    end else if (frame_ok) begin
      if (frame.cmd == CMD_CFG_A) begin
        pd_a_d = frame.data[PD_BIT];
        srst_d = frame.data[SRST_BIT];
      end
      if (frame.cmd == CMD_CFG_B) begin
        pd_b_d = frame.data[PD_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_a_q <= 1'b0;
      pd_b_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      pd_a_q <= pd_a_d;
      pd_b_q <= pd_b_d;
      srst_q <= srst_d;
    end
  end

  assign input_reg = in_q;
  assign dac_latch = lat_q;
  assign pd_a      = pd_a_q;
  assign pd_b      = pd_b_q;

endmodule

// File: rtl/dac_rstpd_ctrl.sv
module dac_rstpd_ctrl
  import dac_rpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FRAME_BITS  = 24
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              mid_strap,
  input  logic              fmt_twos,
  input  logic              pd_pin,
  input  logic              cs_n,
  input  logic              bit_strobe,
  input  logic              bit_in,
  output logic              rst_active,
  output logic              frame_drop,
  output logic              pd_en,
  output logic [DATA_W-1:0] input_reg,
  output logic [DATA_W-1:0] dac_latch
);

  logic   rst_raw_n;
  logic   rst_n_sync;
  logic   frame_ok;
  frame_t frame;
  logic   pd_a, pd_b;
  logic   srst_q;

  assign rst_raw_n = por_n && rst_pin_n;

  rpd_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_raw_n  (rst_raw_n),
    .rst_n_sync (rst_n_sync)
  );

  rpd_frame_track #(.FRAME_BITS(FRAME_BITS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cs_n       (cs_n),
    .bit_strobe (bit_strobe),
    .bit_in     (bit_in),
    .frame_ok   (frame_ok),
    .frame      (frame),
    .poisoned   (frame_drop)
  );

  rpd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .frame_ok   (frame_ok),
    .frame      (frame),
    .fmt_twos   (fmt_twos),
    .mid_strap  (mid_strap),
    .input_reg  (input_reg),
    .dac_latch  (dac_latch),
    .pd_a       (pd_a),
    .pd_b       (pd_b),
    .srst_q     (srst_q)
  );

  assign rst_active = !rst_n_sync || srst_q;
  assign pd_en      = pd_pin || pd_a || pd_b;

endmodule

// File: rtl/dac_rstpd_chk.sv
module dac_rstpd_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_pin_n,
  input logic              mid_strap,
  input logic              pd_pin,
  input logic              rst_active,
  input logic              frame_drop,
  input logic              pd_en,
  input logic [DATA_W-1:0] input_reg,
  input logic [DATA_W-1:0] dac_latch,
  input logic              rst_n_sync,
  input logic              frame_ok,
  input logic              srst_q
);

  assert_quiet_needs_pins_R2: assert property (@(posedge clk) disable iff (!por_n)
    !rst_active |-> rst_pin_n);

  assert_drop_after_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n_sync |=> frame_drop);

  assert_sw_reset_loads_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    srst_q |=> (input_reg == (mid_strap ? 16'h8000 : 16'h0000)));

  assert_pin_forces_pd_R8: assert property (@(posedge clk) disable iff (!por_n)
    pd_pin |-> pd_en);

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!frame_ok && !srst_q) |=> $stable(dac_latch));

endmodule

bind dac_rstpd_ctrl dac_rstpd_chk #(.DATA_W(16)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_pin_n  (rst_pin_n),
  .mid_strap  (mid_strap),
  .pd_pin     (pd_pin),
  .rst_active (rst_active),
  .frame_drop (frame_drop),
  .pd_en      (pd_en),
  .input_reg  (input_reg),
  .dac_latch  (dac_latch),
  .rst_n_sync (rst_n_sync),
  .frame_ok   (frame_ok),
  .srst_q     (srst_q)
);

// File: tb/test_dac_rstpd_ctrl.sv
`timescale 1ns/1ps
module test_dac_rstpd_ctrl;

  logic        clk = 1'b0;
  logic        por_n, rst_pin_n, mid_strap, fmt_twos, pd_pin;
  logic        cs_n, bit_strobe, bit_in;
  logic        rst_active, frame_drop, pd_en;
  logic [15:0] input_reg, dac_latch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dac_rstpd_ctrl i_dac_rstpd_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .mid_strap(mid_strap),
    .fmt_twos(fmt_twos), .pd_pin(pd_pin), .cs_n(cs_n), .bit_strobe(bit_strobe),
    .bit_in(bit_in), .rst_active(rst_active), .frame_drop(frame_drop),
    .pd_en(pd_en), .input_reg(input_reg), .dac_latch(dac_latch)
  );

  // fmt(1) cmd(4) data(16) expected input_reg(16) expected dac_latch(16)
  localparam int NVEC = 8;
  localparam logic [52:0] VEC [NVEC] = '{
    {1'b0, 4'h1, 16'h1234, 16'h1234, 16'h0000},
    {1'b0, 4'h2, 16'h5A5A, 16'h1234, 16'h1234},
    {1'b1, 4'h3, 16'h0005, 16'h8005, 16'h8005},
    {1'b1, 4'h1, 16'h8000, 16'h0000, 16'h8005},
    {1'b0, 4'h7, 16'hFFFF, 16'h0000, 16'h8005},
    {1'b1, 4'h2, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 4'h3, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b1, 4'h1, 16'h7FFF, 16'hFFFF, 16'hFFFF}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [3:0] cmd, input logic [15:0] data, input int n);
    logic [23:0] w;
    w = {4'h0, cmd, data};
    for (int i = 0; i < n; i++) begin
      bit_in     = (i < 24) ? w[23-i] : 1'b0;
      bit_strobe = 1'b1;
      tick();
    end
    bit_strobe = 1'b0;
  endtask

  task automatic send(input logic [3:0] cmd, input logic [15:0] data, input int n);
    cs_n = 1'b0;
    tick();
    shift_bits(cmd, data, n);
    cs_n = 1'b1;
    tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b1; mid_strap = 1'b0; fmt_twos = 1'b0;
    pd_pin = 1'b0; cs_n = 1'b1; bit_strobe = 1'b0; bit_in = 1'b0;
    tick(); tick(); tick();
    chk(rst_active == 1'b1, "R1 por rst_active", 16'(rst_active), 16'h1);
    chk(input_reg == 16'h0000, "R1 por input_reg", input_reg, 16'h0000);
    chk(dac_latch == 16'h0000, "R1 por dac_latch", dac_latch, 16'h0000);
    por_n = 1'b1;
    tick();
    chk(rst_active == 1'b1, "R2 first edge", 16'(rst_active), 16'h1);
    tick();
    chk(rst_active == 1'b0, "R2 second edge", 16'(rst_active), 16'h0);
    tick();
    chk(frame_drop == 1'b0, "R6 idle drop", 16'(frame_drop), 16'h0);

    // R4 R5 R11 vector walk
    for (int v = 0; v < NVEC; v++) begin
      fmt_twos = VEC[v][52];
      send(VEC[v][51:48], VEC[v][47:32], 24);
      chk(input_reg == VEC[v][31:16], "R4/R5/R11 vec input_reg", input_reg, VEC[v][31:16]);
      chk(dac_latch == VEC[v][15:0],  "R4/R5/R11 vec dac_latch", dac_latch, VEC[v][15:0]);
    end
    fmt_twos = 1'b0;

    // R1 pin reset with midscale strap
    mid_strap = 1'b1;
    rst_pin_n = 1'b0;
    tick();
    chk(rst_active == 1'b1, "R1 pin rst_active", 16'(rst_active), 16'h1);
    chk(input_reg == 16'h8000, "R1 pin input_reg", input_reg, 16'h8000);
    chk(dac_latch == 16'h8000, "R1 pin dac_latch", dac_latch, 16'h8000);
    rst_pin_n = 1'b1;
    tick();
    chk(rst_active == 1'b1, "R2 pin first edge", 16'(rst_active), 16'h1);
    tick();
    chk(rst_active == 1'b0, "R2 pin second edge", 16'(rst_active), 16'h0);

    // R3 wrong lengths
    send(4'h3, 16'h1111, 23);
    chk(input_reg == 16'h8000, "R3 short frame", input_reg, 16'h8000);
    send(4'h3, 16'h1111, 25);
    chk(dac_latch == 16'h8000, "R3 long frame", dac_latch, 16'h8000);

    // R7 software reset
    send(4'h3, 16'h4444, 24);
    send(4'h4, 16'h8000, 23);
    chk(rst_active == 1'b0, "R7 invalid no reset", 16'(rst_active), 16'h0);
    tick();
    chk(input_reg == 16'h4444, "R7 invalid keeps", input_reg, 16'h4444);
    send(4'h4, 16'hC000, 24);
    chk(rst_active == 1'b1, "R7 pulse", 16'(rst_active), 16'h1);
    chk(input_reg == 16'h4444, "R7 not yet", input_reg, 16'h4444);
    tick();
    chk(input_reg == 16'h8000, "R7 input_reg", input_reg, 16'h8000);
    chk(dac_latch == 16'h8000, "R7 dac_latch", dac_latch, 16'h8000);
    chk(pd_en == 1'b0, "R7 pd cleared", 16'(pd_en), 16'h0);
    chk(rst_active == 1'b0, "R7 pulse ends", 16'(rst_active), 16'h0);

    // R8 R9 R10 power-down
    pd_pin = 1'b1;
    tick();
    chk(pd_en == 1'b1, "R8 pin", 16'(pd_en), 16'h1);
    send(4'h4, 16'h4000, 24);
    pd_pin = 1'b0;
    tick();
    chk(pd_en == 1'b1, "R8 bit A", 16'(pd_en), 16'h1);
    send(4'hC, 16'h4000, 24);
    send(4'h4, 16'h0000, 24);
    chk(pd_en == 1'b1, "R9 bit B holds", 16'(pd_en), 16'h1);
    send(4'h3, 16'h2222, 24);
    chk(input_reg == 16'h2222, "R10 write in pd", input_reg, 16'h2222);
    send(4'hC, 16'h0000, 24);
    chk(pd_en == 1'b0, "R9 all clear", 16'(pd_en), 16'h0);
    chk(dac_latch == 16'h2222, "R10 kept on exit", dac_latch, 16'h2222);

    // R6 pin reset inside a frame
    cs_n = 1'b0;
    tick();
    shift_bits(4'h3, 16'hABCD, 10);
    rst_pin_n = 1'b0;
    tick();
    rst_pin_n = 1'b1;
    tick(); tick(); tick();
    chk(frame_drop == 1'b1, "R6 drop flag", 16'(frame_drop), 16'h1);
    shift_bits(4'h3, 16'hABCD, 24);
    cs_n = 1'b1;
    tick();
    chk(input_reg == 16'h8000, "R6 no commit", input_reg, 16'h8000);
    chk(frame_drop == 1'b0, "R6 flag clears", 16'(frame_drop), 16'h0);
    send(4'h3, 16'hABCD, 24);
    chk(dac_latch == 16'hABCD, "R6 next frame ok", dac_latch, 16'hABCD);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule